// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the start of each received frame as a stream of bytes. It collects the six bytes of the destination address and classifies the address as individual, group or all-stations. It then decides whether the frame should be kept. An individual address must equal the programmed 48-bit station identity exactly. A group address is reduced to a 6-bit hash, and that hash selects one entry of a 64-entry acceptance table. The all-ones address is governed by its own enable. An accept-everything mode overrides every other rule.

Bytes that follow the address (source address, length field, payload) pass the block without effect. The station identity and the hash table are written through a small byte-wide register port. Writes are honoured only when no address capture is in progress. The four acceptance controls are static level inputs. They are evaluated together with the captured address when the decision is presented.

Top module: `rxaddr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0, the station identity and every hash table entry are 0, and no capture is in progress.
- R2: A byte taken with `rx_valid` and `rx_sof` both high is address byte 0. The next five bytes taken with `rx_valid` high (and `rx_sof` low) are address bytes 1 to 5. `dec_valid` is high for exactly one cycle: the cycle that follows the clock edge at which byte 5 is taken. Later bytes of the same frame never raise `dec_valid` again.
- R3: `dec_type` reports the address class while `dec_valid` is high: 2'b10 when all 48 bits are 1, otherwise 2'b01 when bit 0 of byte 0 (the group bit) is 1, otherwise 2'b00. The value 2'b11 never appears. `dec_accept` is 0 whenever `dec_valid` is 0.
- R4: An individual address (class 2'b00) is accepted when `mode_phys_en` is 1 and address byte i equals station byte i for all i from 0 to 5.
- R5: An all-ones address is accepted if and only if `mode_bcast_en` or `mode_promisc` is 1. The hash table has no effect on it.
- R6: A group address that is not all ones is accepted when `mode_mcast_en` is 1 and table entry H is 1. H is found as follows. Start a 32-bit register at all ones. Feed in the six address bytes in order, each one least-significant bit first. For each bit, XOR the data bit with register bit 0, shift the register right by one, and if the XOR result was 1, XOR the register with 32'hEDB88320. H is bits 31 down to 26 of the final register.
- R7: When `mode_promisc` is 1, every frame is accepted whatever its address or class.
- R8: A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr` on the clock edge. Addresses 0 to 5 hold station bytes 0 to 5. Addresses 8 to 15 hold the table: bit b of address 8+k is table entry 8*k+b. Other addresses store nothing.
- R9: A write is ignored while a capture is in progress, that is, after address byte 0 and before address byte 5 has been taken.
- R10: Cycles with `rx_valid` low inside the address leave the capture unchanged. The values on `rx_byte` in those cycles have no effect.
- R11: A byte taken with `rx_sof` high always restarts the capture at byte 0, even in the middle of an earlier address. The partial address produces no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | `rx_byte` carries a received byte this cycle |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by `rx_valid`) |
| rx_byte | input | 8 | Received byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| mode_promisc | input | 1 | Accept every frame |
| mode_phys_en | input | 1 | Enable exact-match individual reception |
| mode_bcast_en | input | 1 | Enable all-ones reception |
| mode_mcast_en | input | 1 | Enable hashed group reception |
| dec_valid | output | 1 | One-cycle pulse: decision is valid |
| dec_accept | output | 1 | Frame accepted (only when `dec_valid`) |
| dec_type | output | 2 | Address class: 00 individual, 01 group, 10 all-ones |

## Verification
On every cycle, the assertions check the following: the decision pulse lasts one cycle and follows a taken byte; the class code is legal; acceptance is absent outside the pulse; the override and each disable force the expected outcome for their class; and the stored configuration cannot change during a capture. Whether an individual address matched bit for bit, whether the hash picked the right table entry, how gaps and restarts were handled and whether the register map was decoded correctly are judged only by the bench. It compares each decision against its own model of the station identity, the table and the hash.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  // Reflected form of the frame check polynomial
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    AK_PHYS  = 2'b00,
    AK_MCAST = 2'b01,
    AK_BCAST = 2'b10
  } addr_kind_e;

  // One byte through the bit-serial CRC, least-significant bit first
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  d);
    logic [31:0] r;
    logic        fb;
    r = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = {1'b0, r[31:1]};
      if (fb) r = r ^ CRC_POLY_REFL;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxaf_capture.sv
module rxaf_capture #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rx_valid,
  input  logic                             rx_sof,
  input  logic [7:0]                       rx_byte,
  output logic [ADDR_BYTES-1:0][7:0]       addr_q,
  output logic [HASH_BITS-1:0]             hash_q,
  output logic                             done_q,
  output logic                             busy
);
  import rxaf_pkg::*;

  localparam int CW = $clog2(ADDR_BYTES + 1);

  logic [CW-1:0] cnt_q;
  logic [31:0]   crc_q;
  logic          take;
  logic [CW-1:0] slot;
  logic [31:0]   crc_base;
  logic [31:0]   crc_next;
  logic          last_byte;

  // A byte is taken on a start marker, or while the address is incomplete
  assign take      = rx_valid && (rx_sof || (cnt_q != '0 && cnt_q != CW'(ADDR_BYTES)));
  assign slot      = rx_sof ? '0 : cnt_q;
  assign crc_base  = rx_sof ? CRC_SEED : crc_q;
  assign crc_next  = crc_step_byte(crc_base, rx_byte);
  assign last_byte = take && (slot == CW'(ADDR_BYTES - 1));
  assign busy      = (cnt_q != '0) && (cnt_q != CW'(ADDR_BYTES));
  assign hash_q    = crc_q[31 -: HASH_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      crc_q  <= CRC_SEED;
      done_q <= 1'b0;
      addr_q <= '0;
    end else begin
      done_q <= last_byte;
      if (take) begin
        cnt_q <= slot + CW'(1);
        crc_q <= crc_next;
        for (int g = 0; g < ADDR_BYTES; g++) begin
          if (slot == CW'(g)) addr_q[g] <= rx_byte;
        end
      end
    end
  end

endmodule

// File: rtl/rxaf_cfg_regs.sv
module rxaf_cfg_regs #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int CFG_AW     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [7:0]                   cfg_wdata,
  input  logic                         lock,
  output logic [ADDR_BYTES-1:0][7:0]   sta_q,
  output logic [(1<<HASH_BITS)-1:0]    tbl_q
);

  localparam int TBL_ENTRIES = 1 << HASH_BITS;
  localparam int TBL_BYTES   = TBL_ENTRIES / 8;
  localparam int TBL_BASE    = 1 << $clog2(ADDR_BYTES);

  logic [TBL_BYTES-1:0][7:0] tbl_b;
  logic                      wr_ok;

  assign wr_ok = cfg_we && !lock;
  assign tbl_q = tbl_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_q <= '0;
      tbl_b <= '0;
    end else if (wr_ok) begin
      for (int g = 0; g < ADDR_BYTES; g++) begin
        if (cfg_addr == CFG_AW'(g)) sta_q[g] <= cfg_wdata;
      end
      for (int t = 0; t < TBL_BYTES; t++) begin
        if (cfg_addr == CFG_AW'(TBL_BASE + t)) tbl_b[t] <= cfg_wdata;
      end
    end
  end

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic [ADDR_BYTES-1:0][7:0]   addr,
  input  logic [ADDR_BYTES-1:0][7:0]   sta,
  input  logic [(1<<HASH_BITS)-1:0]    tbl,
  input  logic [HASH_BITS-1:0]         hash,
  input  logic                         promisc,
  input  logic                         phys_en,
  input  logic                         bcast_en,
  input  logic                         mcast_en,
  output logic                         accept,
  output logic [1:0]                   kind
);
  import rxaf_pkg::*;

  logic [ADDR_BYTES-1:0] byte_eq;
  logic [ADDR_BYTES-1:0] byte_ones;
  logic                  is_bcast;
  logic                  is_group;
  logic                  sta_hit;
  logic                  hash_hit;
  addr_kind_e            kind_e;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_cmp
    assign byte_eq[g]   = (addr[g] == sta[g]);
    assign byte_ones[g] = &addr[g];
  end

  assign is_bcast = &byte_ones;
  assign is_group = addr[0][0];
  assign sta_hit  = &byte_eq;
  assign hash_hit = tbl[hash];

  always_comb begin
    if (is_bcast)      kind_e = AK_BCAST;
    else if (is_group) kind_e = AK_MCAST;
    else               kind_e = AK_PHYS;
  end

  always_comb begin
    unique case (kind_e)
      AK_BCAST: accept = promisc || bcast_en;
      AK_MCAST: accept = promisc || (mcast_en && hash_hit);
      default:  accept = promisc || (phys_en && sta_hit);
    endcase
  end

  assign kind = kind_e;

endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int CFG_AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_byte,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              mode_promisc,
  input  logic              mode_phys_en,
  input  logic              mode_bcast_en,
  input  logic              mode_mcast_en,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [1:0]        dec_type
);

  localparam int TBL_ENTRIES = 1 << HASH_BITS;

  logic [ADDR_BYTES-1:0][7:0] addr_w;
  logic [ADDR_BYTES-1:0][7:0] sta_w;
  logic [TBL_ENTRIES-1:0]     tbl_w;
  logic [HASH_BITS-1:0]       hash_w;
  logic                       done_w;
  logic                       busy_w;
  logic                       acc_w;
  logic [1:0]                 kind_w;

  rxaf_capture #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_sof   (rx_sof),
    .rx_byte  (rx_byte),
    .addr_q   (addr_w),
    .hash_q   (hash_w),
    .done_q   (done_w),
    .busy     (busy_w)
  );

  rxaf_cfg_regs #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS), .CFG_AW(CFG_AW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .lock      (busy_w),
    .sta_q     (sta_w),
    .tbl_q     (tbl_w)
  );

  rxaf_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_dec (
    .addr     (addr_w),
    .sta      (sta_w),
    .tbl      (tbl_w),
    .hash     (hash_w),
    .promisc  (mode_promisc),
    .phys_en  (mode_phys_en),
    .bcast_en (mode_bcast_en),
    .mcast_en (mode_mcast_en),
    .accept   (acc_w),
    .kind     (kind_w)
  );

  assign dec_valid  = done_w;
  assign dec_accept = done_w && acc_w;
  assign dec_type   = kind_w;

endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker #(
  parameter int ADDR_BYTES  = 6,
  parameter int TBL_ENTRIES = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rx_valid,
  input logic                    cfg_we,
  input logic                    busy,
  input logic [ADDR_BYTES*8-1:0] sta_flat,
  input logic [TBL_ENTRIES-1:0]  tbl_flat,
  input logic                    promisc,
  input logic                    phys_en,
  input logic                    bcast_en,
  input logic                    mcast_en,
  input logic                    dec_valid,
  input logic                    dec_accept,
  input logic [1:0]              dec_type
);

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R2
  AST_PULSE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(rx_valid)); // R2
  AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_type != 2'b11)); // R3
  AST_NO_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept); // R3
  AST_PHYS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_type == 2'b00 && !promisc && !phys_en) |-> !dec_accept); // R4
  AST_BCAST_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_type == 2'b10) |-> (dec_accept == (promisc || bcast_en))); // R5
  AST_MCAST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_type == 2'b01 && !promisc && !mcast_en) |-> !dec_accept); // R6
  AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && promisc) |-> dec_accept); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we) |=> ($stable(sta_flat) && $stable(tbl_flat))); // R9

endmodule

bind rxaddr_filter rxaf_checker #(
  .ADDR_BYTES  (ADDR_BYTES),
  .TBL_ENTRIES (TBL_ENTRIES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .cfg_we     (cfg_we),
  .busy       (busy_w),
  .sta_flat   (sta_w),
  .tbl_flat   (tbl_w),
  .promisc    (mode_promisc),
  .phys_en    (mode_phys_en),
  .bcast_en   (mode_bcast_en),
  .mcast_en   (mode_mcast_en),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .dec_type   (dec_type)
);

// File: tb/rxaddr_filter_tb_top.sv
`timescale 1ns/1ps
module rxaddr_filter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_sof;
  logic [7:0] rx_byte;
  logic       cfg_we;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       mode_promisc, mode_phys_en, mode_bcast_en, mode_mcast_en;
  logic       dec_valid, dec_accept;
  logic [1:0] dec_type;

  int vectors = 0;
  int fails   = 0;

  logic [47:0] sta_m;
  logic [63:0] tbl_m;

  always #5 clk = ~clk;

  rxaddr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mode_promisc(mode_promisc), .mode_phys_en(mode_phys_en),
    .mode_bcast_en(mode_bcast_en), .mode_mcast_en(mode_mcast_en),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_type(dec_type)
  );

  // Hash: serial walk over all 48 address bits, wire order
  function automatic logic [5:0] bench_hash(input logic [47:0] a);
    logic [31:0] reg32;
    logic        b;
    reg32 = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      b = a[k] ^ reg32[0];
      reg32 = reg32 >> 1;
      reg32 = b ? (reg32 ^ 32'hEDB8_8320) : reg32;
    end
    return reg32[31:26];
  endfunction

  // {accept, type}
  function automatic logic [2:0] bench_expect(input logic [47:0] a);
    logic [1:0] ty;
    logic       ok;
    ty = (a == {48{1'b1}}) ? 2'b10 : (a[0] ? 2'b01 : 2'b00);
    ok = mode_promisc;
    if (ty == 2'b00 && mode_phys_en && a == sta_m) ok = 1'b1;
    if (ty == 2'b10 && mode_bcast_en) ok = 1'b1;
    if (ty == 2'b01 && mode_mcast_en && tbl_m[bench_hash(a)]) ok = 1'b1;
    return {ok, ty};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d, input bit model);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (model) begin
      if (a < 4'd6) sta_m[8*a +: 8] = d;
      else if (a >= 4'd8) tbl_m[8*(a-8) +: 8] = d;
    end
  endtask

  task automatic set_modes(input logic pr, input logic ph, input logic bc, input logic mc);
    @(negedge clk);
    mode_promisc = pr; mode_phys_en = ph; mode_bcast_en = bc; mode_mcast_en = mc;
  endtask

  // Sends a frame; gap_max idle cycles between bytes; payload bytes after address
  task automatic send_frame(input logic [47:0] a, input int gap_max, input int payload,
                            input string req);
    logic [2:0] e;
    for (int i = 0; i < 6; i++) begin
      int gaps;
      gaps = (gap_max > 0) ? $urandom_range(gap_max, 0) : 0;
      for (int j = 0; j < gaps; j++) begin
        @(negedge clk);
        if (i > 0) check("R10 no early decision", {7'd0, dec_valid}, 8'd0);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_byte = 8'($urandom);
      end
      @(negedge clk);
      if (i > 0) check("R2 no decision before byte 5", {7'd0, dec_valid}, 8'd0);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = a[8*i +: 8];
    end
    @(negedge clk);
    e = bench_expect(a);
    check({req, " R2 valid"}, {7'd0, dec_valid}, 8'd1);
    check({req, " R3 type"}, {6'd0, dec_type}, {6'd0, e[1:0]});
    check({req, " accept"}, {7'd0, dec_accept}, {7'd0, e[2]});
    rx_valid = 1'b0; rx_sof = 1'b0;
    for (int p = 0; p < payload; p++) begin
      rx_valid = 1'b1; rx_byte = 8'($urandom);
      @(negedge clk);
      check("R2 payload ignored", {6'd0, dec_valid, dec_accept}, 8'd0);
    end
    rx_valid = 1'b0;
  endtask

  logic [47:0] mc_a;

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; rx_byte = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    mode_promisc = 0; mode_phys_en = 0; mode_bcast_en = 0; mode_mcast_en = 0;
    sta_m = '0; tbl_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", {7'd0, dec_valid}, 8'd0);
    check("R1 reset accept", {7'd0, dec_accept}, 8'd0);

    // R1: zero station identity matches an all-zero address after reset
    set_modes(0, 1, 0, 0);
    send_frame(48'h0, 0, 2, "R1 zero station");

    // R8: program station identity
    for (int i = 0; i < 6; i++) cfg_write(4'(i), (i == 0) ? 8'h02 : 8'(8'h10 + i), 1);
    cfg_write(4'd6, 8'hAA, 1);  // unmapped, no effect
    set_modes(0, 1, 1, 1);
    send_frame(sta_m, 0, 3, "R4 exact match");
    send_frame(sta_m ^ 48'h0100_0000_0000, 0, 1, "R4 one bit off");
    set_modes(0, 0, 1, 1);
    send_frame(sta_m, 0, 1, "R4 phys disabled");

    // R5: all-ones with enables
    set_modes(0, 0, 1, 0);
    send_frame({48{1'b1}}, 1, 2, "R5 bcast on");
    set_modes(0, 1, 0, 1);
    tbl_m = '0;
    for (int t = 0; t < 8; t++) cfg_write(4'(8 + t), 8'hFF, 1);
    send_frame({48{1'b1}}, 0, 1, "R5 bcast off, table full");

    // R6/R8: a single table bit controls a group address
    for (int t = 0; t < 8; t++) cfg_write(4'(8 + t), 8'h00, 1);
    mc_a = 48'h0000_5E00_0001;
    set_modes(0, 0, 0, 1);
    send_frame(mc_a, 0, 1, "R6 table empty");
    cfg_write(4'(8 + bench_hash(mc_a) / 8), 8'(1 << (bench_hash(mc_a) % 8)), 1);
    send_frame(mc_a, 0, 1, "R6 single entry set");
    set_modes(0, 0, 0, 0);
    send_frame(mc_a, 0, 1, "R6 mcast disabled");

    // R7: promiscuous accepts a foreign individual address
    set_modes(1, 0, 0, 0);
    send_frame(48'h0000_1234_5678, 0, 1, "R7 promisc");

    // R9: write during capture ignored
    set_modes(0, 1, 0, 0);
    @(negedge clk); rx_valid = 1; rx_sof = 1; rx_byte = sta_m[7:0];
    @(negedge clk); rx_sof = 0; rx_byte = sta_m[15:8];
    cfg_we = 1; cfg_addr = 4'd0; cfg_wdata = 8'h66;
    for (int i = 2; i < 6; i++) begin
      @(negedge clk); cfg_we = 0; rx_byte = sta_m[8*i +: 8];
    end
    @(negedge clk); rx_valid = 0;
    check("R9 frame during write", {7'd0, dec_accept}, 8'd1);
    send_frame(sta_m, 0, 0, "R9 station unchanged");

    // R11: restart mid-address
    @(negedge clk); rx_valid = 1; rx_sof = 1; rx_byte = 8'hFF;
    @(negedge clk); rx_sof = 0; rx_byte = 8'hFF;
    @(negedge clk); rx_byte = 8'hFF;
    send_frame(sta_m, 0, 1, "R11 restart");

    // Random phase
    for (int n = 0; n < 300; n++) begin
      logic [47:0] a;
      int cls;
      if (n % 25 == 0)
        for (int t = 0; t < 8; t++) cfg_write(4'(8 + t), 8'($urandom), 1);
      set_modes(($urandom_range(7, 0) == 0), 1'($urandom), 1'($urandom), 1'($urandom));
      cls = $urandom_range(3, 0);
      a = {16'($urandom), 32'($urandom)};
      case (cls)
        0: a = sta_m;
        1: a = {48{1'b1}};
        2: a[0] = 1'b1;
        default: a[0] = 1'b0;
      endcase
      send_frame(a, 2, $urandom_range(4, 0), "R2-random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule